// File: doc/BRIEF.md
# GPIO Output Set/Clear Port Controller

This block drives the output side of one general-purpose port of `PIN_W` pins (32 by default). Software never does a read-modify-write on the output value. It writes ones into a "set" view to raise pins, or ones into a "clear" view to lower them. Zero bits in either write leave their pins alone, so two agents can change separate pins of the same port without racing each other.

Each write is gated per pin by three things:
- a mask register, which locks pins against change;
- a direction register, which marks pins as outputs;
- a function-select input, which hands a pin to a secondary function outside this block.

The bus port carries byte strobes, one per group of eight pins. The same view can therefore be written as a full word, as either half-word or as any single byte. Output enables go high only for pins that are outputs and that no secondary function has taken.

Top module: `gpio_setclr_port`

## Requirements
- R1: After reset, `pin_out` and `pin_oe` are all zero, and reads of the direction, mask, set and clear views all return zero.
- R2: A write to the set view (offset 0x8) drives each gated pin whose data bit is 1 to HIGH from the next cycle on. A read of the set view returns the current output value.
- R3: A write to the clear view (offset 0xC) drives each gated pin whose data bit is 1 to LOW from the next cycle on. A later read of the set view shows that bit as 0.
- R4: Data bits that are 0 in a set or clear write leave their pins unchanged.
- R5: A set or clear write does not change a pin whose direction bit is 0 (input) or whose `func_sel` bit is 1 (secondary function). With no set or clear write, `pin_out` holds its value.
- R6: A set or clear write does not change a pin whose mask bit is 1. Mask bit 0 means the pin is accessible.
- R7: Byte strobe `be[k]` enables pins 8k..8k+7, and their data sits in `wdata[8k+7:8k]`. This allows word, half-word (`be`=0011 or 1100) and byte accesses. The address must be word aligned: `addr[1:0]`=0.
- R8: The clear view is write-only, and a read of it always returns zero.
- R9: The direction view (offset 0x0) and the mask view (offset 0x4) can be read and written. A write changes only the bytes whose strobes are set.
- R10: `pin_oe` bit n is 1 exactly when direction bit n is 1 and `func_sel` bit n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address of the view, word aligned |
| we | input | 1 | Write enable |
| be | input | PIN_W/8 | Byte strobes, one per eight pins |
| wdata | input | PIN_W | Write data |
| rdata | output | PIN_W | Read data, combinational from `addr` |
| func_sel | input | PIN_W | 1 = pin belongs to a secondary function |
| pin_out | output | PIN_W | Pin output values |
| pin_oe | output | PIN_W | Pin output enables |

## Verification
A register write lands on the clock edge that samples it. `pin_out` and the register read-back therefore change one cycle after the write is presented. `rdata` and `pin_oe` are combinational and follow `addr`, `func_sel` and the stored registers in the same cycle.

The bench drives every input on the falling edge. After each write it inspects `pin_out` at the next falling edge, half a cycle after the edge that took the write. Reads are sampled one nanosecond after the address is applied.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;
   typedef enum logic [1:0] {
      VIEW_DIR  = 2'd0,
      VIEW_MASK = 2'd1,
      VIEW_SET  = 2'd2,
      VIEW_CLR  = 2'd3
   } view_e;

   localparam int unsigned LANE_W = 8;
endpackage

// File: rtl/gpio_sc_decode.sv
module gpio_sc_decode
   import gpio_sc_pkg::*;
#(
   parameter int unsigned PIN_W  = 32,
   parameter int unsigned ADDR_W = 4
) (
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    we,
   input  logic [PIN_W/LANE_W-1:0] be,
   output view_e                   view,
   output logic                    hit,
   output logic                    wr_dir,
   output logic                    wr_mask,
   output logic                    wr_set,
   output logic                    wr_clr,
   output logic [PIN_W-1:0]        lane_bits
);
   localparam int unsigned LANES = PIN_W / LANE_W;

   logic upper_ok;

   generate
      if (ADDR_W > 4) begin : g_upper
         assign upper_ok = (addr[ADDR_W-1:4] == '0);
      end else begin : g_no_upper
         assign upper_ok = 1'b1;
      end
   endgenerate

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         assign lane_bits[g*LANE_W +: LANE_W] = {LANE_W{be[g]}};
      end
   endgenerate

   always_comb begin
      view    = view_e'(addr[3:2]);
      hit     = upper_ok && (addr[1:0] == 2'b00);
      wr_dir  = we && hit && (view == VIEW_DIR);
      wr_mask = we && hit && (view == VIEW_MASK);
      wr_set  = we && hit && (view == VIEW_SET);
      wr_clr  = we && hit && (view == VIEW_CLR);
   end
endmodule

// File: rtl/gpio_sc_rwreg.sv
module gpio_sc_rwreg #(
   parameter int unsigned PIN_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [PIN_W-1:0] lane_bits,
   input  logic [PIN_W-1:0] wdata,
   output logic [PIN_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (wr) begin
         q <= (q & ~lane_bits) | (wdata & lane_bits);
      end
   end
endmodule

// File: rtl/gpio_sc_outreg.sv
module gpio_sc_outreg #(
   parameter int unsigned PIN_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_set,
   input  logic             wr_clr,
   input  logic [PIN_W-1:0] lane_bits,
   input  logic [PIN_W-1:0] wdata,
   input  logic [PIN_W-1:0] mask_q,
   input  logic [PIN_W-1:0] dir_q,
   input  logic [PIN_W-1:0] func_sel,
   output logic [PIN_W-1:0] out_q
);
   logic [PIN_W-1:0] gate;
   logic [PIN_W-1:0] touch;

   always_comb begin
      gate  = lane_bits & ~mask_q & dir_q & ~func_sel;
      touch = wdata & gate;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= '0;
      end else if (wr_clr) begin
         out_q <= out_q & ~touch;
      end else if (wr_set) begin
         out_q <= out_q | touch;
      end
   end
endmodule

// File: rtl/gpio_setclr_port.sv
module gpio_setclr_port
   import gpio_sc_pkg::*;
#(
   parameter int unsigned PIN_W  = 32,
   parameter int unsigned ADDR_W = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    we,
   input  logic [PIN_W/LANE_W-1:0] be,
   input  logic [PIN_W-1:0]        wdata,
   output logic [PIN_W-1:0]        rdata,
   input  logic [PIN_W-1:0]        func_sel,
   output logic [PIN_W-1:0]        pin_out,
   output logic [PIN_W-1:0]        pin_oe
);
   generate
      if ((PIN_W % LANE_W) != 0 || PIN_W < LANE_W) begin : g_bad_pin_w
         $error("PIN_W must be a non-zero multiple of 8");
      end
      if (ADDR_W < 4) begin : g_bad_addr_w
         $error("ADDR_W must be at least 4");
      end
   endgenerate

   view_e            view;
   logic             hit;
   logic             wr_dir, wr_mask, wr_set, wr_clr;
   logic [PIN_W-1:0] lane_bits;
   logic [PIN_W-1:0] dir_q;
   logic [PIN_W-1:0] mask_q;
   logic [PIN_W-1:0] out_q;

   gpio_sc_decode #(.PIN_W(PIN_W), .ADDR_W(ADDR_W)) u_dec (
      .addr(addr), .we(we), .be(be), .view(view), .hit(hit),
      .wr_dir(wr_dir), .wr_mask(wr_mask), .wr_set(wr_set), .wr_clr(wr_clr),
      .lane_bits(lane_bits)
   );

   gpio_sc_rwreg #(.PIN_W(PIN_W)) u_dir (
      .clk(clk), .rst_n(rst_n), .wr(wr_dir), .lane_bits(lane_bits),
      .wdata(wdata), .q(dir_q)
   );

   gpio_sc_rwreg #(.PIN_W(PIN_W)) u_mask (
      .clk(clk), .rst_n(rst_n), .wr(wr_mask), .lane_bits(lane_bits),
      .wdata(wdata), .q(mask_q)
   );

   gpio_sc_outreg #(.PIN_W(PIN_W)) u_out (
      .clk(clk), .rst_n(rst_n), .wr_set(wr_set), .wr_clr(wr_clr),
      .lane_bits(lane_bits), .wdata(wdata), .mask_q(mask_q), .dir_q(dir_q),
      .func_sel(func_sel), .out_q(out_q)
   );

   always_comb begin
      rdata = '0;
      if (hit) begin
         unique case (view)
            VIEW_DIR:  rdata = dir_q;
            VIEW_MASK: rdata = mask_q;
            VIEW_SET:  rdata = out_q;
            VIEW_CLR:  rdata = '0;
         endcase
      end
   end

   assign pin_out = out_q;
   assign pin_oe  = dir_q & ~func_sel;
endmodule

// File: rtl/gpio_sc_chk.sv
module gpio_sc_chk #(
   parameter int unsigned PIN_W  = 32,
   parameter int unsigned ADDR_W = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   addr,
   input logic                we,
   input logic [PIN_W/8-1:0]  be,
   input logic [PIN_W-1:0]    wdata,
   input logic [PIN_W-1:0]    rdata,
   input logic [PIN_W-1:0]    func_sel,
   input logic [PIN_W-1:0]    pin_out,
   input logic [PIN_W-1:0]    pin_oe,
   input logic [PIN_W-1:0]    dir_q,
   input logic [PIN_W-1:0]    mask_q
);
   logic [PIN_W-1:0] strobe_bits;
   logic [PIN_W-1:0] eff;
   logic             at_set, at_clr;

   always_comb begin
      for (int i = 0; i < PIN_W; i++) begin
         strobe_bits[i] = be[i/8];
      end
      eff    = wdata & strobe_bits & ~mask_q & dir_q & ~func_sel;
      at_set = (addr == ADDR_W'(8));
      at_clr = (addr == ADDR_W'(12));
   end

   AST_CLR_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (we && at_clr) |=> ((pin_out & $past(eff)) == '0)); // R3
   AST_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (we && at_set) |=> ((pin_out & $past(eff)) == $past(eff))); // R2
   AST_UNGATED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (we && (at_set || at_clr)) |=> (((pin_out ^ $past(pin_out)) & ~$past(eff)) == '0)); // R4
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && (at_set || at_clr)) |=> $stable(pin_out)); // R5
   AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      at_clr |-> (rdata == '0)); // R8
   AST_OE_NO_SECONDARY: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_oe & func_sel) == '0)); // R10
endmodule

bind gpio_setclr_port gpio_sc_chk #(.PIN_W(PIN_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .be(be), .wdata(wdata),
   .rdata(rdata), .func_sel(func_sel), .pin_out(pin_out), .pin_oe(pin_oe),
   .dir_q(dir_q), .mask_q(mask_q)
);

// File: tb/sim_gpio_setclr_port.sv
module sim_gpio_setclr_port;
   localparam logic [3:0] A_DIR = 4'h0, A_MASK = 4'h4, A_SET = 4'h8, A_CLR = 4'hC;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  addr = '0;
   logic        we = 1'b0;
   logic [3:0]  be = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [31:0] func_sel = '0;
   logic [31:0] pin_out;
   logic [31:0] pin_oe;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   gpio_setclr_port #(.PIN_W(32), .ADDR_W(4)) u0 (
      .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .be(be), .wdata(wdata),
      .rdata(rdata), .func_sel(func_sel), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   typedef struct packed {
      logic [3:0]  view;
      logic [3:0]  be;
      logic [31:0] wdata;
      logic [31:0] dir;
      logic [31:0] mask;
      logic [31:0] fsel;
      logic [31:0] pre;
      logic [31:0] exp;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{A_CLR, 4'hF, 32'h0000_00FF, 32'hFFFF_FFFF, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FF00}, // R3
      '{A_CLR, 4'hF, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0, 32'h0, 32'hA5A5_A5A5, 32'hA5A5_A5A5}, // R4
      '{A_SET, 4'hF, 32'h0F0F_0000, 32'hFFFF_FFFF, 32'h0, 32'h0, 32'h0000_0000, 32'h0F0F_0000}, // R2
      '{A_CLR, 4'hF, 32'hFFFF_FFFF, 32'h0000_FFFF, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_0000}, // R5
      '{A_CLR, 4'hF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'hFF00_0000, 32'hFFFF_FFFF, 32'hFF00_0000}, // R5
      '{A_CLR, 4'hF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h00FF_00FF, 32'h0, 32'hFFFF_FFFF, 32'h00FF_00FF}, // R6
      '{A_CLR, 4'h2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_00FF}, // R7 byte
      '{A_CLR, 4'hC, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0000_FFFF}, // R7 half
      '{A_SET, 4'h8, 32'h1234_5678, 32'hFFFF_FFFF, 32'h0, 32'h0, 32'h0000_0000, 32'h1200_0000}, // R7 byte
      '{A_SET, 4'hF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_0000, 32'h0, 32'h0000_0000, 32'h0000_FFFF}, // R6
      '{A_SET, 4'hF, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0, 32'h0, 32'h0000_0000, 32'h0000_0000}  // R5
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [3:0] a, input logic [3:0] strb, input logic [31:0] d);
      @(negedge clk);
      addr = a; we = 1'b1; be = strb; wdata = d;
      @(negedge clk);
      we = 1'b0; be = '0; wdata = '0;
   endtask

   task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a; we = 1'b0;
      #1;
      d = rdata;
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
   end

   initial begin
      logic [31:0] r;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 pin_out", pin_out, 32'h0);
      check("R1 pin_oe", pin_oe, 32'h0);
      rst_n = 1'b1;
      bus_rd(A_DIR, r);  check("R1 dir", r, 32'h0);
      bus_rd(A_MASK, r); check("R1 mask", r, 32'h0);
      bus_rd(A_SET, r);  check("R1 set view", r, 32'h0);
      bus_rd(A_CLR, r);  check("R1 clr view", r, 32'h0);

      // vector table: preset output, configure gating, apply one view write
      for (int i = 0; i < NV; i++) begin
         func_sel = '0;
         bus_wr(A_DIR, 4'hF, 32'hFFFF_FFFF);
         bus_wr(A_MASK, 4'hF, 32'h0);
         bus_wr(A_CLR, 4'hF, 32'hFFFF_FFFF);
         bus_wr(A_SET, 4'hF, VECS[i].pre);
         bus_wr(A_DIR, 4'hF, VECS[i].dir);
         bus_wr(A_MASK, 4'hF, VECS[i].mask);
         func_sel = VECS[i].fsel;
         bus_wr(VECS[i].view, VECS[i].be, VECS[i].wdata);
         check($sformatf("vector %0d pin_out", i), pin_out, VECS[i].exp);
      end

      // R3: set view reads 0 after clear
      func_sel = '0;
      bus_wr(A_MASK, 4'hF, 32'h0);
      bus_wr(A_DIR, 4'hF, 32'hFFFF_FFFF);
      bus_wr(A_SET, 4'hF, 32'hFFFF_FFFF);
      bus_wr(A_CLR, 4'h1, 32'h0000_0081);
      bus_rd(A_SET, r); check("R3 set view after clear", r, 32'hFFFF_FF7E);
      // R2: set view reads output value
      bus_wr(A_SET, 4'h1, 32'h0000_0001);
      bus_rd(A_SET, r); check("R2 set view read", r, 32'hFFFF_FF7F);
      // R8: clear view reads zero with outputs high
      bus_rd(A_CLR, r); check("R8 clr view read", r, 32'h0);
      // R9: byte-lane write of mask touches only its lane
      bus_wr(A_MASK, 4'h4, 32'hAABB_CCDD);
      bus_rd(A_MASK, r); check("R9 mask lane", r, 32'h00BB_0000);
      bus_wr(A_DIR, 4'h3, 32'h1234_0000);
      bus_rd(A_DIR, r); check("R9 dir half", r, 32'hFFFF_0000);
      // R10: output enable follows dir and func_sel
      func_sel = 32'hF000_000F;
      #1;
      check("R10 pin_oe", pin_oe, 32'h0FFF_0000);
      // R5: func_sel change alone leaves pin_out
      check("R5 hold", pin_out, 32'hFFFF_FF7F);
      // R7: misaligned address is ignored
      bus_wr(4'h9, 4'hF, 32'hFFFF_FFFF);
      check("R7 misaligned", pin_out, 32'hFFFF_FF7F);
      summary();
   end
endmodule